// File: doc/BRIEF.md
# SDRAM Device-Side Command Engine

This block is the memory-device end of a DDR2-style SDRAM link, written as synthesizable logic. On each rising clock edge it samples the active-low select and command strobes, the clock-enable, a bank select, a multiplexed address bus and the write data lanes. It decodes the basic command set and moves through a small state machine: initialization, idle, mode programming, row open, burst read, burst write, precharge, refresh and active power-down.

Data lives in an internal register array indexed by bank, row and column. An activate opens one bank and row. Later reads and writes stream eight words through that open row. Read data is released after the programmed CAS latency. Write data is taken after a write latency one cycle shorter. The column order within the burst is either sequential or interleaved. A byte mask protects selected lanes during writes. Commands that break the protocol have no effect and raise a sticky error flag. These are commands arriving while a burst, refresh or one-cycle recovery is running, and accesses made without an open row.

The bidirectional data bus is split into an input port, an output port and an output-enable, with a separate data-valid qualifier. A controller model or a system-level bench drives the command pins as it would drive a real device.

Top module: `sdram_target`

## Requirements
- R1: After reset the engine is in its initialization state, dq_oe, dq_valid and proto_err are low, dq_out is zero, the CAS latency is 3 and the burst order is sequential.
- R2: With cs_n low, {ras_n,cas_n,we_n} decodes as 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set; 111 and 110 are no-operation. With cs_n high every edge is a no-operation, whatever the other strobes hold.
- R3: In the initialization state only a precharge is accepted, and it moves the engine to idle. Any other non-NOP command is ignored and sets proto_err.
- R4: A mode set in idle with ba equal to zero loads the CAS latency from addr[6:4] and the burst order from addr[3] (0 sequential, 1 interleaved). With ba non-zero it is an extended set that leaves both unchanged. The engine then spends one recovery cycle before it returns to idle.
- R5: An activate in idle latches ba as the open bank and addr[ROW_W-1:0] as the open row. A read or write then uses that bank and row, with its starting column taken from addr[COL_W-1:0].
- R6: A read sampled at edge n with CAS latency c returns its first word on dq_out after edge n+max(c,1). Eight words follow on consecutive edges. dq_oe and dq_valid are high for exactly those eight cycles and dq_out is zero otherwise. The row stays open afterwards.
- R7: A write sampled at edge n with CAS latency c stores dq_in at edges n+max(c-1,1) through n+max(c-1,1)+7, one word per edge.
- R8: Burst word i goes to column {base[COL_W-1:3], low}. Here low is (base[2:0]+i) mod 8 in sequential order and base[2:0] XOR i in interleaved order.
- R9: During a write beat, dm[k]=1 leaves byte lane k (dq bits 8k+7..8k) of the addressed word unchanged.
- R10: A refresh is accepted only in idle. Commands sampled on the REF_CYC-1 edges after it are ignored and set proto_err. A command at edge n+REF_CYC is accepted.
- R11: With a row open and no burst running, cke low at an edge enters power-down and that edge's command is ignored. While powered down all commands are ignored without error. The first edge with cke high returns to the open-row state and ignores its command. The open row survives.
- R12: proto_err goes high and stays high until reset in these cases: a read or write with no row open; any non-NOP command during a burst; an activate, refresh or mode set while a row is open. None of these commands changes the stored data or the engine's state.
- R13: A precharge with a row open closes it. A command on the next edge is ignored and sets proto_err, and the engine is idle from the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable, low requests power-down |
| cs_n | input | 1 | Active-low chip select |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| we_n | input | 1 | Active-low write strobe |
| ba | input | BANK_W | Bank select |
| addr | input | ADDR_W | Row, column or mode-register contents |
| dq_in | input | DATA_W | Write data lanes |
| dm | input | DATA_W/8 | Per-byte write mask, high protects the lane |
| dq_out | output | DATA_W | Read data |
| dq_oe | output | 1 | Drive enable for the data bus |
| dq_valid | output | 1 | Read data qualifier |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
The bench builds the engine with its defaults: 8 banks, 4 rows, 16 columns, 16-bit data and an 8-cycle refresh. Sixteen columns give two aligned 8-word blocks, so burst wrap in both orders shows up within one row. A cycle-accurate reference model checks every edge against CAS latencies 3, 5 and 1. These cover both write-latency clamps and the longest burst window. The small array lets the model track every written word, so masked writes, ignored commands and power-down are all confirmed by reading the data back.

// File: rtl/sdrt_pkg.sv
package sdrt_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF,
        CMD_MRS
    } cmd_e;

    typedef enum logic [3:0] {
        ST_INIT,
        ST_IDLE,
        ST_MRS,
        ST_REF,
        ST_ACT,
        ST_PDN,
        ST_RD,
        ST_WR,
        ST_PRE
    } state_e;

    localparam int unsigned BURST_LEN = 8;
    localparam int unsigned BURST_W   = $clog2(BURST_LEN);

endpackage

// File: rtl/sdrt_cmd_decode.sv
module sdrt_cmd_decode
    import sdrt_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_MRS;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdrt_array.sv
module sdrt_array #(
    parameter int DATA_W = 16,
    parameter int AW     = 9
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [AW-1:0]         addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [DATA_W/8-1:0]   keep,
    output logic [DATA_W-1:0]     rd_data
);

    localparam int LANES = DATA_W / 8;
    localparam int DEPTH = 1 << AW;

    // One byte-wide store per lane so a masked lane is simply not written.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && !keep[g]) begin
                mem_q[addr] <= wr_data[g*8 +: 8];
            end
        end

        assign rd_data[g*8 +: 8] = mem_q[addr];
    end

endmodule

// File: rtl/sdram_target.sv
module sdram_target
    import sdrt_pkg::*;
#(
    parameter int BANK_W   = 3,
    parameter int ROW_W    = 2,
    parameter int COL_W    = 4,
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 16,
    parameter int REF_CYC  = 8,
    parameter int CL_RESET = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cke,
    input  logic                  cs_n,
    input  logic                  ras_n,
    input  logic                  cas_n,
    input  logic                  we_n,
    input  logic [BANK_W-1:0]     ba,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     dq_in,
    input  logic [DATA_W/8-1:0]   dm,
    output logic [DATA_W-1:0]     dq_out,
    output logic                  dq_oe,
    output logic                  dq_valid,
    output logic                  proto_err
);

    localparam int AW      = BANK_W + ROW_W + COL_W;
    localparam int CNT_TOP = (REF_CYC > 2 * BURST_LEN) ? REF_CYC : 2 * BURST_LEN;
    localparam int CNT_W   = $clog2(CNT_TOP + 1);

    typedef struct packed {
        state_e              st;
        logic [CNT_W-1:0]    cnt;
        logic [BANK_W-1:0]   bank;
        logic [ROW_W-1:0]    row;
        logic [COL_W-1:0]    col;
        logic [2:0]          cl;
        logic                ilv;
        logic                err;
        logic                oe;
        logic [DATA_W-1:0]   dout;
    } regs_t;

    regs_t q, d;
    cmd_e  cmd;

    logic [2:0]          rl, wl;
    logic [CNT_W-1:0]    lat;
    logic                beat, last;
    logic [BURST_W-1:0]  idx, low;
    logic [AW-1:0]       arr_addr;
    logic                arr_we;
    logic [DATA_W-1:0]   arr_rdata;
    logic                unused_addr_bits;

    assign unused_addr_bits = ^addr;

    sdrt_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    sdrt_array #(.DATA_W(DATA_W), .AW(AW)) u_arr (
        .clk     (clk),
        .wr_en   (arr_we),
        .addr    (arr_addr),
        .wr_data (dq_in),
        .keep    (dm),
        .rd_data (arr_rdata)
    );

    // Burst addressing: latency window, beat index and column order.
    always_comb begin
        rl       = (q.cl == 3'd0) ? 3'd1 : q.cl;
        wl       = (q.cl <= 3'd2) ? 3'd1 : q.cl - 3'd1;
        lat      = (q.st == ST_WR) ? CNT_W'(wl) : CNT_W'(rl);
        beat     = ((q.st == ST_RD) || (q.st == ST_WR)) && (q.cnt >= lat);
        idx      = BURST_W'(q.cnt - lat);
        last     = beat && (idx == BURST_W'(BURST_LEN - 1));
        low      = q.ilv ? (q.col[BURST_W-1:0] ^ idx) : (q.col[BURST_W-1:0] + idx);
        arr_addr = {q.bank, q.row, q.col[COL_W-1:BURST_W], low};
        arr_we   = beat && (q.st == ST_WR);
    end

    // Next-state computation for every register.
    always_comb begin
        d      = q;
        d.oe   = 1'b0;
        d.dout = '0;
        case (q.st)
            ST_INIT: begin
                if (cmd == CMD_PRE)      d.st  = ST_IDLE;
                else if (cmd != CMD_NOP) d.err = 1'b1;
            end
            ST_IDLE: begin
                case (cmd)
                    CMD_ACT: begin
                        d.st   = ST_ACT;
                        d.bank = ba;
                        d.row  = addr[ROW_W-1:0];
                    end
                    CMD_REF: begin
                        d.st  = ST_REF;
                        d.cnt = CNT_W'(1);
                    end
                    CMD_MRS: begin
                        d.st = ST_MRS;
                        if (ba == '0) begin
                            d.cl  = addr[6:4];
                            d.ilv = addr[3];
                        end
                    end
                    CMD_RD, CMD_WR: d.err = 1'b1;
                    default: ;
                endcase
            end
            ST_MRS, ST_PRE: begin
                d.st = ST_IDLE;
                if (cmd != CMD_NOP) d.err = 1'b1;
            end
            ST_REF: begin
                if (cmd != CMD_NOP) d.err = 1'b1;
                d.cnt = q.cnt + CNT_W'(1);
                if (q.cnt == CNT_W'(REF_CYC - 1)) d.st = ST_IDLE;
            end
            ST_ACT: begin
                if (!cke) begin
                    d.st = ST_PDN;
                end else begin
                    case (cmd)
                        CMD_RD, CMD_WR: begin
                            d.st  = (cmd == CMD_RD) ? ST_RD : ST_WR;
                            d.cnt = CNT_W'(1);
                            d.col = addr[COL_W-1:0];
                        end
                        CMD_PRE: d.st  = ST_PRE;
                        CMD_NOP: ;
                        default: d.err = 1'b1;
                    endcase
                end
            end
            ST_PDN: begin
                if (cke) d.st = ST_ACT;
            end
            ST_RD, ST_WR: begin
                if (cmd != CMD_NOP) d.err = 1'b1;
                d.cnt = q.cnt + CNT_W'(1);
                if (beat && (q.st == ST_RD)) begin
                    d.oe   = 1'b1;
                    d.dout = arr_rdata;
                end
                if (last) d.st = ST_ACT;
            end
            default: d.st = ST_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_INIT;
            q.cl   <= 3'(CL_RESET);
        end else begin
            q <= d;
        end
    end

    assign dq_out    = q.dout;
    assign dq_oe     = q.oe;
    assign dq_valid  = q.oe;
    assign proto_err = q.err;

    // R3: the only way out of initialization is into idle.
    p_init_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st) == ST_INIT) && (q.st != ST_INIT) |-> (q.st == ST_IDLE));

    // R5: a read burst can only start from an open row.
    p_rd_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RD) && ($past(q.st) != ST_RD) |-> ($past(q.st) == ST_ACT));

    // R6: when read data stops, the row has just been returned to open.
    p_oe_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_oe) |-> ($past(q.st) == ST_ACT));

    // R10: the refresh phase never outlasts its cycle budget.
    p_ref_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_REF) |-> (q.cnt < CNT_W'(REF_CYC)));

    // R11: power-down is entered only from an open, quiet row.
    p_pdn_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PDN) |-> (($past(q.st) == ST_ACT) || ($past(q.st) == ST_PDN)));

    // R12: the error flag never clears without reset.
    p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

endmodule

// File: tb/sdram_target_tb.sv
`timescale 1ns/1ps
module sdram_target_tb;

    localparam int ROWS = 4;
    localparam int COLS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [2:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [1:0]  dm = '0;
    logic [15:0] dq_out;
    logic        dq_oe, dq_valid, proto_err;

    always #4 clk = ~clk;

    sdram_target u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dq_in(dq_in),
        .dm(dm), .dq_out(dq_out), .dq_oe(dq_oe), .dq_valid(dq_valid),
        .proto_err(proto_err)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    dm_mode = 0;
    bit    done = 0;
    int    dcnt = 0;

    // ---------------- reference model ----------------
    int          m_e = 0, m_busy = 0, m_cl = 3, m_bank = 0, m_row = 0;
    bit          m_init = 1, m_open = 0, m_pd = 0, m_err = 0, m_ilv = 0;
    bit          rd_v [64];
    int          rd_k [64];
    bit          wr_v [64];
    int          wr_k [64];
    logic [15:0] mm [int];
    logic        exp_oe = 0;
    logic [15:0] exp_dout = '0;

    function automatic int col_of(int base, int i, bit ilv);
        int lo;
        lo = ilv ? ((base % 8) ^ i) : ((base + i) % 8);
        return (base / 8) * 8 + lo;
    endfunction

    function automatic int key_of(int b, int r, int c);
        return (b * ROWS + r) * COLS + c;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_e = 0; m_busy = 0; m_cl = 3; m_init = 1; m_open = 0;
            m_pd = 0; m_err = 0; m_ilv = 0; exp_oe = 0; exp_dout = '0;
            for (int i = 0; i < 64; i++) begin rd_v[i] = 0; wr_v[i] = 0; end
        end else begin
            int slot, lat, base, k;
            bit nop;
            logic [2:0] rcw;
            logic [15:0] nw;
            m_e++;
            slot = m_e % 64;
            exp_oe = 0;
            exp_dout = '0;
            if (rd_v[slot]) begin
                exp_oe = 1;
                exp_dout = mm.exists(rd_k[slot]) ? mm[rd_k[slot]] : 16'h0;
                rd_v[slot] = 0;
            end
            if (wr_v[slot]) begin
                k = wr_k[slot];
                nw = mm.exists(k) ? mm[k] : 16'h0;
                if (!dm[0]) nw[7:0] = dq_in[7:0];
                if (!dm[1]) nw[15:8] = dq_in[15:8];
                mm[k] = nw;
                wr_v[slot] = 0;
            end
            rcw = {ras_n, cas_n, we_n};
            nop = cs_n || (rcw[2:1] == 2'b11);
            if (m_e <= m_busy) begin
                if (!nop) m_err = 1;
            end else if (m_init) begin
                if (!nop && rcw == 3'b010) m_init = 0;
                else if (!nop) m_err = 1;
            end else if (m_pd) begin
                if (cke) m_pd = 0;
            end else if (m_open && !cke) begin
                m_pd = 1;
            end else if (!nop) begin
                if (!m_open) begin
                    case (rcw)
                        3'b011: begin m_open = 1; m_bank = ba; m_row = addr % ROWS; end
                        3'b001: m_busy = m_e + 7;
                        3'b000: begin
                            m_busy = m_e + 1;
                            if (ba == 0) begin m_cl = addr[6:4]; m_ilv = addr[3]; end
                        end
                        3'b101, 3'b100: m_err = 1;
                        default: ;
                    endcase
                end else begin
                    case (rcw)
                        3'b101, 3'b100: begin
                            if (rcw == 3'b101) lat = (m_cl < 1) ? 1 : m_cl;
                            else lat = (m_cl - 1 < 1) ? 1 : m_cl - 1;
                            base = addr % COLS;
                            for (int i = 0; i < 8; i++) begin
                                int s;
                                s = (m_e + lat + i) % 64;
                                if (rcw == 3'b101) begin
                                    rd_v[s] = 1; rd_k[s] = key_of(m_bank, m_row, col_of(base, i, m_ilv));
                                end else begin
                                    wr_v[s] = 1; wr_k[s] = key_of(m_bank, m_row, col_of(base, i, m_ilv));
                                end
                            end
                            m_busy = m_e + lat + 7;
                        end
                        3'b010: begin m_open = 0; m_busy = m_e + 1; end
                        default: m_err = 1;
                    endcase
                end
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (!done) begin
            n_chk++;
            if (dq_oe !== exp_oe || dq_valid !== exp_oe) begin
                n_fail++;
                $display("FAIL %s dq_oe=%b dq_valid=%b expected %b", tag, dq_oe, dq_valid, exp_oe);
            end
            n_chk++;
            if (dq_out !== exp_dout) begin
                n_fail++;
                $display("FAIL %s dq_out=%h expected %h", tag, dq_out, exp_dout);
            end
            n_chk++;
            if (proto_err !== m_err) begin
                n_fail++;
                $display("FAIL %s proto_err=%b expected %b", tag, proto_err, m_err);
            end
        end
    end

    always @(negedge clk) begin
        dcnt++;
        dq_in <= 16'(dcnt * 16'h1357) ^ 16'h2c4b;
        dm    <= dm_mode ? 2'(dcnt) : 2'b00;
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [2:0] rcw, input logic [2:0] b, input logic [12:0] a);
        cs_n = 1'b0; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a;
        @(negedge clk);
        cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cke = 1'b1; dm_mode = 0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic check_eq(input string t, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected %0h", t, act, exp);
        end
    endtask

    localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                           C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000;

    initial begin
        idle(2);
        tag = "R1";
        check_eq("R1 reset oe", {31'd0, dq_oe}, 0);
        check_eq("R1 reset err", {31'd0, proto_err}, 0);
        check_eq("R1 reset dout", {16'd0, dq_out}, 0);
        do_reset();

        tag = "R3";  send(C_PRE, 0, 0); idle(1);
        tag = "R4";  send(C_MRS, 0, 13'(3 << 4)); idle(2);
        tag = "R5";  send(C_ACT, 5, 13'd2); idle(1);
        tag = "R7 R8"; send(C_WR, 0, 13'd4); idle(14);
        tag = "R6";  send(C_RD, 0, 13'd4); idle(14);
        tag = "R2";
        cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b000; idle(2);
        cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b110; idle(1);
        cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; idle(1);
        check_eq("R2 deselect no error", {31'd0, proto_err}, 0);
        tag = "R9";  dm_mode = 1; send(C_WR, 0, 13'd4); idle(14);
        dm_mode = 0; send(C_RD, 0, 13'd4); idle(14);
        tag = "R13"; send(C_PRE, 0, 0); idle(2);
        tag = "R4";  send(C_MRS, 0, 13'((5 << 4) | 8)); idle(2);
        send(C_MRS, 1, 13'(2 << 4)); idle(2);
        tag = "R8";  send(C_ACT, 2, 13'd1); idle(1);
        send(C_WR, 0, 13'd10); idle(16);
        send(C_RD, 0, 13'd13); idle(16);
        tag = "R11"; cke = 1'b0; send(C_RD, 0, 13'd10); idle(3);
        cke = 1'b1; idle(1);
        send(C_RD, 0, 13'd10); idle(16);
        tag = "R6";  send(C_PRE, 0, 0); idle(2);
        send(C_MRS, 0, 13'(1 << 4)); idle(2);
        send(C_ACT, 2, 13'd1); idle(1);
        send(C_WR, 0, 13'd9); idle(12);
        send(C_RD, 0, 13'd9); idle(12);
        tag = "R10"; send(C_PRE, 0, 0); idle(2);
        send(C_REF, 0, 0); idle(7);
        send(C_ACT, 2, 13'd1); idle(1);
        send(C_RD, 0, 13'd9); idle(12);
        check_eq("R10 clean refresh", {31'd0, proto_err}, 0);

        tag = "R3";  do_reset(); send(C_RD, 0, 0); idle(2);
        check_eq("R3 command before init precharge", {31'd0, proto_err}, 1);

        tag = "R12"; do_reset(); send(C_PRE, 0, 0); send(C_RD, 0, 0); idle(2);
        check_eq("R12 read without open row", {31'd0, proto_err}, 1);

        tag = "R10"; do_reset(); send(C_PRE, 0, 0); idle(1);
        send(C_REF, 0, 0); idle(5); send(C_ACT, 1, 0); idle(3);
        check_eq("R10 command during refresh", {31'd0, proto_err}, 1);

        tag = "R12"; do_reset(); send(C_PRE, 0, 0); idle(1);
        send(C_ACT, 3, 13'd3); idle(1);
        send(C_WR, 0, 13'd0); idle(14);
        send(C_RD, 0, 13'd0); idle(2);
        send(C_WR, 0, 13'd0); idle(14);
        send(C_RD, 0, 13'd0); idle(14);
        check_eq("R12 write during read burst", {31'd0, proto_err}, 1);

        tag = "R13"; do_reset(); send(C_PRE, 0, 0); idle(1);
        send(C_ACT, 0, 0); idle(1); send(C_PRE, 0, 0); send(C_ACT, 0, 0); idle(2);
        check_eq("R13 command in precharge cycle", {31'd0, proto_err}, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
            $finish;
        end
    end

endmodule